// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Break Detection

This block turns a serial input line into received characters. The line is retimed by a short flop chain and then sampled against an oversampling enable that pulses `OS_RATE` times per bit period. The start of a character is qualified at the middle of its first bit. Each later bit is taken at its own middle. A small set of line-control inputs selects the character length, whether a parity bit follows the data, and which parity sense is expected.

For every character the block raises a one-cycle valid strobe. It also presents the data, right-aligned, and three tags: parity mismatch, missing stop bit, and line break. A stop bit sampled low marks the character as badly framed, and that same low sample is then taken as the start bit of the following character, so the receiver falls back into step without waiting for an idle line. A line that stays low through an entire frame yields one all-zero character tagged as a break. No further character is accepted until the line has gone high again.

The divisor that produces the oversampling enable, any character buffering, software registers and the transmit path live outside this block.

Top module: `serial_char_rx`

## Requirements
- R1: After reset `char_valid`, `char_data`, `par_err`, `frm_err` and `brk_det` are all zero.
- R2: A falling edge starts a character only if the line is still low `OS_RATE/2` enable pulses after the edge was seen. A shorter low pulse produces no character.
- R3: Data bits arrive least significant first. `len_sel` value 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits. Bits of `char_data` above the selected length are zero.
- R4: When `par_en` is 1, one parity bit follows the data. With `par_even` = 1 the data bits plus the parity bit must hold an even number of ones, and with `par_even` = 0 an odd number; otherwise `par_err` is 1. When `par_en` is 0 no parity bit is expected and `par_err` is 0.
- R5: A stop bit sampled low delivers the character with `frm_err` = 1. A stop bit sampled high delivers it with `frm_err` = 0.
- R6: After a low stop sample (not a break), that sample serves as a confirmed start bit. The next data bits are taken one bit period later and onward, without waiting for the line to go high.
- R7: When start, all data bits, any parity bit and the stop bit are all sampled low, exactly one character is delivered with `char_data` = 0, `brk_det` = 1, `frm_err` = 1, and `par_err` = 1 only if parity is enabled with odd sense.
- R8: After a break character, no character is delivered until the line has returned high. A low line that continues past the frame yields nothing more.
- R9: The length and parity settings are captured when a start bit is confirmed. Changes to them during the character do not affect that character.
- R10: `char_valid` is high for exactly one clock per character. `char_data` and the three tags keep their values until the next character is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, `OS_RATE` pulses per bit period |
| rx_in | input | 1 | Serial input line, idle high |
| len_sel | input | 2 | Data length select: 0..3 gives 5..8 bits |
| par_en | input | 1 | 1 = parity bit present and checked |
| par_even | input | 1 | 1 = even parity expected, 0 = odd |
| char_valid | output | 1 | One-cycle strobe for a delivered character |
| char_data | output | 8 | Received data, right-aligned |
| par_err | output | 1 | Parity mismatch tag |
| frm_err | output | 1 | Stop bit sampled low |
| brk_det | output | 1 | Break character tag |

## Verification
Delivering a badly framed character and confirming the start of the next one happen on the same stop-sample enable. The bench provokes this by sending a frame whose stop bit is held low and following it at once with the data bits of a second character, with and without parity. It judges the result by requiring two delivered characters: the first carries the framing tag, and the second carries correct data with clean tags. A held-low line exercises the second overlap, where the framing tag and the break tag are raised together on one character. Here the bench requires a single all-zero delivery whose parity tag depends on the parity sense, and silence until the line recovers.

// File: rtl/srx_pkg.sv
package srx_pkg;
   localparam int unsigned CHAR_W  = 8;
   localparam int unsigned LEN_MIN = 5;
   localparam int unsigned IDX_W   = $clog2(CHAR_W);

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_HOLD
   } rx_state_e;

   typedef struct packed {
      logic [1:0] len;
      logic       par_en;
      logic       par_even;
   } line_cfg_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_phase.sv
module srx_phase #(
   parameter int unsigned OS_RATE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   input  logic half,
   output logic sample
);
   localparam int unsigned CW = $clog2(OS_RATE);
   localparam logic [CW-1:0] HALF_LAST = CW'(OS_RATE / 2 - 1);
   localparam logic [CW-1:0] FULL_LAST = CW'(OS_RATE - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] target;

   assign target = half ? HALF_LAST : FULL_LAST;
   assign sample = tick && !restart && (cnt == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (restart)        cnt <= '0;
      else if (tick) begin
         if (cnt == target)    cnt <= '0;
         else                  cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/srx_parity.sv
module srx_parity
   import srx_pkg::*;
(
   input  logic [CHAR_W-1:0] data,
   input  logic [1:0]        len,
   input  logic              en,
   input  logic              even,
   input  logic              pbit,
   output logic              bad
);
   logic [CHAR_W-1:0] keep;

   for (genvar i = 0; i < CHAR_W; i++) begin : g_keep
      if (i < LEN_MIN) begin : g_fixed
         assign keep[i] = 1'b1;
      end else begin : g_var
         assign keep[i] = ({30'd0, len} > 32'(i - LEN_MIN));
      end
   end

   assign bad = en & ((^(data & keep)) ^ pbit ^ ~even);
endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic              sample,
   input  line_cfg_t         cfg_in,
   input  logic              par_bad,
   output logic              restart,
   output logic              half,
   output line_cfg_t         cfg_q,
   output logic [CHAR_W-1:0] shift_q,
   output logic              pbit_q,
   output logic              char_valid,
   output logic [CHAR_W-1:0] char_data,
   output logic              par_err,
   output logic              frm_err,
   output logic              brk
);
   rx_state_e        state;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] last_idx;
   logic             zero_run;

   assign restart  = (state == RX_IDLE) && tick && !rx;
   assign half     = (state == RX_START);
   assign last_idx = IDX_W'(LEN_MIN - 1) + IDX_W'(cfg_q.len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         idx        <= '0;
         zero_run   <= 1'b0;
         shift_q    <= '0;
         pbit_q     <= 1'b0;
         cfg_q      <= '0;
         char_valid <= 1'b0;
         char_data  <= '0;
         par_err    <= 1'b0;
         frm_err    <= 1'b0;
         brk        <= 1'b0;
      end else begin
         char_valid <= 1'b0;
         unique case (state)
            RX_IDLE: begin
               if (restart) state <= RX_START;
            end
            RX_START: begin
               if (sample) begin
                  if (!rx) begin
                     state    <= RX_DATA;
                     idx      <= '0;
                     shift_q  <= '0;
                     pbit_q   <= 1'b0;
                     zero_run <= 1'b1;
                     cfg_q    <= cfg_in;
                  end else begin
                     state <= RX_IDLE;
                  end
               end
            end
            RX_DATA: begin
               if (sample) begin
                  shift_q[idx] <= rx;
                  zero_run     <= zero_run & ~rx;
                  if (idx == last_idx) state <= cfg_q.par_en ? RX_PAR : RX_STOP;
                  else                 idx   <= idx + 1'b1;
               end
            end
            RX_PAR: begin
               if (sample) begin
                  pbit_q   <= rx;
                  zero_run <= zero_run & ~rx;
                  state    <= RX_STOP;
               end
            end
            RX_STOP: begin
               if (sample) begin
                  char_valid <= 1'b1;
                  char_data  <= shift_q;
                  par_err    <= par_bad;
                  frm_err    <= ~rx;
                  brk        <= ~rx & zero_run;
                  if (rx) begin
                     state <= RX_IDLE;
                  end else if (zero_run) begin
                     state <= RX_HOLD;
                  end else begin
                     // low stop sample doubles as the next start bit
                     state    <= RX_DATA;
                     idx      <= '0;
                     shift_q  <= '0;
                     pbit_q   <= 1'b0;
                     zero_run <= 1'b1;
                     cfg_q    <= cfg_in;
                  end
               end
            end
            RX_HOLD: begin
               if (tick && rx) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
   import srx_pkg::*;
#(
   parameter int unsigned OS_RATE     = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_in,
   input  logic [1:0]        len_sel,
   input  logic              par_en,
   input  logic              par_even,
   output logic              char_valid,
   output logic [CHAR_W-1:0] char_data,
   output logic              par_err,
   output logic              frm_err,
   output logic              brk_det
);
   initial begin
      assert (OS_RATE >= 4 && (OS_RATE % 2) == 0)
         else $error("serial_char_rx: OS_RATE must be even and at least 4");
      assert (SYNC_STAGES >= 2)
         else $error("serial_char_rx: SYNC_STAGES must be at least 2");
   end

   logic              rx_s;
   logic              restart;
   logic              half;
   logic              sample;
   logic              par_bad;
   logic              pbit_q;
   logic [CHAR_W-1:0] shift_q;
   line_cfg_t         cfg_in;
   line_cfg_t         cfg_q;

   assign cfg_in = '{len: len_sel, par_en: par_en, par_even: par_even};

   srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
   );

   srx_phase #(.OS_RATE(OS_RATE)) u_phase (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .restart(restart),
      .half(half), .sample(sample)
   );

   srx_parity u_parity (
      .data(shift_q), .len(cfg_q.len), .en(cfg_q.par_en),
      .even(cfg_q.par_even), .pbit(pbit_q), .bad(par_bad)
   );

   srx_framer u_framer (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s), .sample(sample),
      .cfg_in(cfg_in), .par_bad(par_bad), .restart(restart), .half(half),
      .cfg_q(cfg_q), .shift_q(shift_q), .pbit_q(pbit_q),
      .char_valid(char_valid), .char_data(char_data), .par_err(par_err),
      .frm_err(frm_err), .brk(brk_det)
   );
endmodule

// File: rtl/serial_char_rx_chk.sv
module serial_char_rx_chk
   import srx_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              rx_s,
   input logic              char_valid,
   input logic [CHAR_W-1:0] char_data,
   input logic              par_err,
   input logic              frm_err,
   input logic              brk_det,
   input logic [1:0]        cfg_len,
   input logic              cfg_par_en
);
   logic brk_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      brk_hold <= 1'b0;
      else if (char_valid && brk_det)  brk_hold <= 1'b1;
      else if (rx_s)                   brk_hold <= 1'b0;
   end

   p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      char_valid |=> !char_valid);

   p_hold_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !char_valid |-> ($stable(char_data) && $stable(par_err) &&
                       $stable(frm_err) && $stable(brk_det)));

   p_break_tags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && brk_det) |-> (frm_err && char_data == '0));

   p_parity_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && !$past(cfg_par_en)) |-> !par_err);

   p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      char_valid |-> ((char_data >> (LEN_MIN + $past(cfg_len))) == '0));

   p_quiet_after_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hold |-> !char_valid);
endmodule

bind serial_char_rx serial_char_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .char_valid(char_valid),
   .char_data(char_data), .par_err(par_err), .frm_err(frm_err),
   .brk_det(brk_det), .cfg_len(cfg_q.len), .cfg_par_en(cfg_q.par_en)
);

// File: tb/serial_char_rx_test.sv
module serial_char_rx_test;
   localparam int OSR = 16;
   localparam int BT  = OSR * 2;   // clocks per bit, enable every other clock
   localparam int WDOG = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rx_in = 1'b1;
   logic [1:0] len_sel = 2'd3;
   logic       par_en = 1'b0;
   logic       par_even = 1'b1;
   logic       char_valid;
   logic [7:0] char_data;
   logic       par_err, frm_err, brk_det;

   always #5 clk = ~clk;
   always @(posedge clk) os_tick <= ~os_tick;

   serial_char_rx #(.OS_RATE(OSR), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
      .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
      .char_valid(char_valid), .char_data(char_data), .par_err(par_err),
      .frm_err(frm_err), .brk_det(brk_det)
   );

   int checks = 0, fails = 0, got_n = 0, pulse_bad = 0, cyc = 0;
   bit prev_v = 1'b0, done = 1'b0;
   logic [7:0] cap_d [16];
   bit cap_pe [16], cap_fe [16], cap_bk [16];

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (char_valid) begin
         cap_d[got_n % 16]  = char_data;
         cap_pe[got_n % 16] = par_err;
         cap_fe[got_n % 16] = frm_err;
         cap_bk[got_n % 16] = brk_det;
         got_n++;
         if (prev_v) pulse_bad++;
      end
      prev_v = char_valid;
   end

   function automatic logic [7:0] mask_of(input logic [1:0] len);
      logic [8:0] m;
      m = (9'd1 << (5 + int'(len))) - 9'd1;
      return m[7:0];
   endfunction

   function automatic logic pbit_for(input logic [7:0] d, input logic [1:0] len, input logic even);
      return (^(d & mask_of(len))) ^ ~even;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic v, input int nbits);
      rx_in = v;
      repeat (nbits * BT) @(negedge clk);
   endtask

   task automatic body(input logic [7:0] d, input logic [1:0] len, input bit pen,
                       input bit even, input bit badp);
      for (int i = 0; i < 5 + int'(len); i++) put(d[i], 1);
      if (pen) put(pbit_for(d, len, even) ^ badp, 1);
   endtask

   task automatic expect_char(input int idx, input logic [7:0] d, input bit pe,
                              input bit fe, input bit bk, input string req);
      chk(cap_d[idx % 16] == d, {req, " data"}, cap_d[idx % 16], d);
      chk(cap_pe[idx % 16] == pe, {req, " parity tag"}, cap_pe[idx % 16], pe);
      chk(cap_fe[idx % 16] == fe, {req, " framing tag"}, cap_fe[idx % 16], fe);
      chk(cap_bk[idx % 16] == bk, {req, " break tag"}, cap_bk[idx % 16], bk);
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      wait (cyc >= WDOG);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
         summary();
         $finish;
      end
   end

   initial begin
      int n0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      put(1'b1, 2);

      // R1: reset state
      chk(char_valid == 0 && char_data == 0 && !par_err && !frm_err && !brk_det,
          "R1 reset outputs", {char_valid, char_data, par_err, frm_err, brk_det}, 0);

      // R3 / R4 / R5: sweep length, parity mode and data pattern
      for (int len = 0; len < 4; len++) begin
         for (int mode = 0; mode < 3; mode++) begin
            for (int k = 0; k < 16; k++) begin
               logic [7:0] d, e;
               bit bad;
               len_sel  = 2'(len);
               par_en   = (mode != 0);
               par_even = (mode == 1);
               d   = 8'(k * 17);
               bad = par_en && (k % 3 == 1);
               e   = d & mask_of(2'(len));
               n0  = got_n;
               put(1'b0, 1);
               body(d, 2'(len), par_en, par_even, bad);
               put(1'b1, 2);
               chk(got_n == n0 + 1, "R3 one char per frame", got_n - n0, 1);
               chk(cap_d[n0 % 16] == e, "R3 data bits", cap_d[n0 % 16], e);
               chk(cap_pe[n0 % 16] == bad, "R4 parity check", cap_pe[n0 % 16], bad);
               chk(!cap_fe[n0 % 16] && !cap_bk[n0 % 16], "R5 good stop clean",
                   {cap_fe[n0 % 16], cap_bk[n0 % 16]}, 0);
               chk(char_data == e, "R10 data held", char_data, e);
            end
         end
      end

      // R2: short low pulse is not a start
      len_sel = 2'd3; par_en = 1'b0;
      n0 = got_n;
      rx_in = 1'b0;
      repeat (12) @(negedge clk);
      put(1'b1, 3);
      chk(got_n == n0, "R2 glitch rejected", got_n - n0, 0);

      // R5 / R6: low stop then next character, no parity
      n0 = got_n;
      put(1'b0, 1);
      body(8'h3C, 2'd3, 1'b0, 1'b1, 1'b0);
      put(1'b0, 1);
      body(8'hA5, 2'd3, 1'b0, 1'b1, 1'b0);
      put(1'b1, 2);
      chk(got_n == n0 + 2, "R6 resync char count", got_n - n0, 2);
      expect_char(n0, 8'h3C, 1'b0, 1'b1, 1'b0, "R5 framing");
      expect_char(n0 + 1, 8'hA5, 1'b0, 1'b0, 1'b0, "R6 resync");

      // R6 with 6-bit even parity, first char bad parity
      len_sel = 2'd1; par_en = 1'b1; par_even = 1'b1;
      n0 = got_n;
      put(1'b0, 1);
      body(8'h15, 2'd1, 1'b1, 1'b1, 1'b1);
      put(1'b0, 1);
      body(8'h2A, 2'd1, 1'b1, 1'b1, 1'b0);
      put(1'b1, 2);
      chk(got_n == n0 + 2, "R6 resync parity count", got_n - n0, 2);
      expect_char(n0, 8'h15, 1'b1, 1'b1, 1'b0, "R5 framing parity");
      expect_char(n0 + 1, 8'h2A, 1'b0, 1'b0, 1'b0, "R6 resync parity");

      // R7 / R8: break, 8 bits odd parity
      len_sel = 2'd3; par_en = 1'b1; par_even = 1'b0;
      n0 = got_n;
      put(1'b0, 14);
      chk(got_n == n0 + 1, "R8 single break char", got_n - n0, 1);
      expect_char(n0, 8'h00, 1'b1, 1'b1, 1'b1, "R7 break odd");
      put(1'b1, 2);
      n0 = got_n;
      put(1'b0, 1);
      body(8'h5A, 2'd3, 1'b1, 1'b0, 1'b0);
      put(1'b1, 2);
      chk(got_n == n0 + 1, "R8 recovery count", got_n - n0, 1);
      expect_char(n0, 8'h5A, 1'b0, 1'b0, 1'b0, "R8 recovery");

      // R7: break, 5 bits even parity
      len_sel = 2'd0; par_en = 1'b1; par_even = 1'b1;
      n0 = got_n;
      put(1'b0, 20);
      chk(got_n == n0 + 1, "R8 long low single char", got_n - n0, 1);
      expect_char(n0, 8'h00, 1'b0, 1'b1, 1'b1, "R7 break even");
      put(1'b1, 2);

      // R7: break, 7 bits no parity
      len_sel = 2'd2; par_en = 1'b0;
      n0 = got_n;
      put(1'b0, 12);
      chk(got_n == n0 + 1, "R7 break no parity count", got_n - n0, 1);
      expect_char(n0, 8'h00, 1'b0, 1'b1, 1'b1, "R7 break no parity");
      put(1'b1, 2);

      // R9: settings changed after start confirmation
      len_sel = 2'd3; par_en = 1'b0; par_even = 1'b1;
      n0 = got_n;
      put(1'b0, 1);
      len_sel = 2'd0; par_en = 1'b1;
      body(8'hC3, 2'd3, 1'b0, 1'b1, 1'b0);
      put(1'b1, 2);
      chk(got_n == n0 + 1, "R9 captured config count", got_n - n0, 1);
      expect_char(n0, 8'hC3, 1'b0, 1'b0, 1'b0, "R9 captured config");

      // R10: strobe width over the whole run
      chk(pulse_bad == 0, "R10 single-cycle strobe", pulse_bad, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule